// File: doc/BRIEF.md
# Gain-Matrix Multiply-Accumulate Stage

This stage turns eight scalar weights and eight coefficient matrices of two rows by six columns into a single gain matrix of the same shape. Each gain element is the weighted sum of the eight matching coefficients. The stage then multiplies each row of that gain matrix by a six-entry state vector, which holds four process states followed by two internal states. The result is two outputs. All of this work runs through one shared multiply-add unit, so the stage steps through a fixed schedule one product per clock: the twelve gain elements first, in row-major order, and then the two outputs.

A correction pass is started with the rewind input. It replays the same schedule on the operands captured by the last start and does not read the input ports again. While it runs, it adds an externally supplied offset into the accumulator register of each phase on every cycle. A rewind pass is padded with idle cycles up to a minimum length. This lets passes of several stages finish together. All values are signed Q8.16 with 24 bits.

Top module: `gain_mac_stage`

## Requirements
- R1: After reset, done_o is 0 and every result word in res_o is 0.
- R2: Each product is rounded back to Q8.16 by adding 2^15 and then shifting arithmetically right by 16. The gain element at row r, column c is built by eight accumulation steps t = 0..7. Each step adds the rounded product of scalar t and the coefficient of matrix t at (r, c). Scalar t sits at scal_i[24t +: 24] and that coefficient at coef_i[24(12t + 6r + c) +: 24].
- R3: Result word r (res_o[24r +: 24]) is built by six steps c = 0..5, each adding the rounded product of gain element (r, c) and state entry c (state_i[24c +: 24]). Row 0 is produced before row 1.
- R4: After every accumulation step the accumulator saturates to the range 0x800000 to 0x7FFFFF. This applies to gain elements and results alike.
- R5: A start accepted on clock edge E0 yields a one-cycle done_o pulse that becomes visible after edge E109. At that point both result words hold the new values.
- R6: start_i and rewind_i have no effect from the accepting edge until the done pulse. The run in progress keeps its operands, its timing and its single done pulse.
- R7: A rewind uses the scalars, coefficients and state captured by the most recent start. Port values present at the rewind are not sampled.
- R8: In a rewind pass, gofs_i is added into every gain accumulation step and oofs_i into every output accumulation step. Both additions fall inside the same saturation. In a start pass both offsets are ignored.
- R9: A rewind pass lasts max(108, MIN_RW_LEN) cycles. Its done pulse becomes visible after edge E(that length + 1).
- R10: When start_i and rewind_i are both high in an idle cycle, start wins and a normal pass with fresh operands runs.
- R11: The result words change only on the output-phase steps that complete a row, and they hold their value between passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture operands and run a normal pass |
| rewind_i | input | 1 | Replay the stored operands with offsets |
| scal_i | input | 192 | Eight Q8.16 scalars, scalar t at bits 24t |
| coef_i | input | 2304 | Eight 2x6 Q8.16 matrices, entry (t,r,c) at word 12t+6r+c |
| state_i | input | 144 | Six-entry Q8.16 state vector, entry c at word c |
| gofs_i | input | 24 | Offset added to the gain accumulator in rewind |
| oofs_i | input | 24 | Offset added to the output accumulator in rewind |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| res_o | output | 48 | Two Q8.16 results, row r at bits 24r |

## Verification
The bench keeps the default operand shape of eight terms, two rows and six columns. It raises MIN_RW_LEN to 150, so a rewind pass is padded by 42 idle cycles beyond the 108-cycle schedule, and the padding then shows up directly in the done latency. With a unit state vector, a result equals a single gain element, which exposes the rounding and each gain element by itself. Large operands drive both accumulators into positive and negative saturation. Pulses on start and rewind in the middle of a pass, and changes to the ports before a rewind, test that the stored operands are kept.

// File: rtl/gms_pkg.sv
// Shared types for the gain-matrix multiply-accumulate stage.
// Assumes nothing beyond a single clock domain.
package gms_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAIN,
        PH_OUTP,
        PH_PAD,
        PH_FIN
    } gms_phase_e;
endpackage

// File: rtl/gms_mac_unit.sv
// Combinational multiply-add: rounds a*b back to the fixed-point format
// (add half, arithmetic shift), adds base and offset, saturates to W bits.
// Assumes both factors share the same FRAC fractional bits.
module gms_mac_unit #(
    parameter int W    = 24,
    parameter int FRAC = 16
) (
    input  logic signed [W-1:0] base_i,
    input  logic signed [W-1:0] mul_a_i,
    input  logic signed [W-1:0] mul_b_i,
    input  logic signed [W-1:0] ofs_i,
    output logic signed [W-1:0] sum_o
);
    localparam int PW = 2 * W;
    localparam int SW = 2 * W + 2;
    localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (FRAC - 1);
    localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [PW-1:0] a_x, b_x, prod, rnd;
    logic signed [SW-1:0] tot;

    // Product, rounding and clamped sum.
    always_comb begin
        a_x  = PW'(mul_a_i);
        b_x  = PW'(mul_b_i);
        prod = a_x * b_x;
        rnd  = (prod + HALF) >>> FRAC;
        tot  = SW'(base_i) + SW'(rnd) + SW'(ofs_i);
        if (tot > MAXV)
            sum_o = MAXV[W-1:0];
        else if (tot < MINV)
            sum_o = MINV[W-1:0];
        else
            sum_o = tot[W-1:0];
    end
endmodule

// File: rtl/gms_sequencer.sv
// Schedule generator: gain phase (row, col, term innermost), then output
// phase (row, col innermost), optional padding in rewind passes, then a
// one-cycle finish state that raises done. Ignores start/rewind when busy.
// Assumes NTERM, NROW, NCOL >= 2 and start has priority over rewind.
module gms_sequencer
    import gms_pkg::*;
#(
    parameter int NTERM  = 8,
    parameter int NROW   = 2,
    parameter int NCOL   = 6,
    parameter int RW_LEN = 108,
    parameter int TW     = 3,
    parameter int RWD    = 1,
    parameter int CWD    = 3,
    parameter int STW    = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           rewind_i,
    output gms_phase_e     phase_o,
    output logic [TW-1:0]  term_o,
    output logic [RWD-1:0] row_o,
    output logic [CWD-1:0] col_o,
    output logic [STW-1:0] step_o,
    output logic           rw_o,
    output logic           load_o,
    output logic           first_o,
    output logic           last_o,
    output logic           done_o
);
    gms_phase_e     phase_q;
    logic [TW-1:0]  term_q;
    logic [RWD-1:0] row_q;
    logic [CWD-1:0] col_q;
    logic [STW-1:0] step_q;
    logic           rw_q, done_q, accept;
    logic           term_end, col_end, row_end;

    // Acceptance and index end flags.
    always_comb begin
        accept   = (phase_q == PH_IDLE) && (start_i || rewind_i);
        term_end = (term_q == TW'(NTERM - 1));
        col_end  = (col_q == CWD'(NCOL - 1));
        row_end  = (row_q == RWD'(NROW - 1));
    end

    // Phase and index counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            term_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            step_q  <= '0;
            rw_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_GAIN;
                        rw_q    <= !start_i;
                        term_q  <= '0;
                        row_q   <= '0;
                        col_q   <= '0;
                        step_q  <= '0;
                    end
                end
                PH_GAIN: begin
                    step_q <= step_q + STW'(1);
                    if (term_end) begin
                        term_q <= '0;
                        if (col_end) begin
                            col_q <= '0;
                            if (row_end) begin
                                row_q   <= '0;
                                phase_q <= PH_OUTP;
                            end else begin
                                row_q <= row_q + RWD'(1);
                            end
                        end else begin
                            col_q <= col_q + CWD'(1);
                        end
                    end else begin
                        term_q <= term_q + TW'(1);
                    end
                end
                PH_OUTP: begin
                    step_q <= step_q + STW'(1);
                    if (col_end) begin
                        col_q <= '0;
                        if (row_end) begin
                            row_q   <= '0;
                            phase_q <= (rw_q && step_q < STW'(RW_LEN - 1)) ? PH_PAD : PH_FIN;
                        end else begin
                            row_q <= row_q + RWD'(1);
                        end
                    end else begin
                        col_q <= col_q + CWD'(1);
                    end
                end
                PH_PAD: begin
                    step_q <= step_q + STW'(1);
                    if (step_q == STW'(RW_LEN - 1))
                        phase_q <= PH_FIN;
                end
                PH_FIN:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Done pulse, one cycle after the finish state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= (phase_q == PH_FIN);
    end

    // Output wiring for the datapath.
    always_comb begin
        phase_o = phase_q;
        term_o  = term_q;
        row_o   = row_q;
        col_o   = col_q;
        step_o  = step_q;
        rw_o    = rw_q;
        load_o  = accept && start_i;
        first_o = (phase_q == PH_GAIN) ? (term_q == '0) : (col_q == '0);
        last_o  = (phase_q == PH_GAIN) ? term_end : col_end;
        done_o  = done_q;
    end
endmodule

// File: rtl/gain_mac_stage.sv
// Gain-matrix stage: captures operands on start, accumulates the NROW x NCOL
// gain matrix from NTERM scalar-matrix products, then forms NROW results as
// gain rows times the state vector, all through one multiply-add unit.
// Rewind replays stored operands and adds offsets into the accumulators.
// Assumes operands are signed fixed point with FRAC fractional bits.
module gain_mac_stage
    import gms_pkg::*;
#(
    parameter int W          = 24,
    parameter int FRAC       = 16,
    parameter int NTERM      = 8,
    parameter int NROW       = 2,
    parameter int NCOL       = 6,
    parameter int MIN_RW_LEN = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         rewind_i,
    input  logic [NTERM*W-1:0]           scal_i,
    input  logic [NTERM*NROW*NCOL*W-1:0] coef_i,
    input  logic [NCOL*W-1:0]            state_i,
    input  logic [W-1:0]                 gofs_i,
    input  logic [W-1:0]                 oofs_i,
    output logic                         done_o,
    output logic [NROW*W-1:0]            res_o
);
    localparam int RUN_LEN = NROW * NCOL * NTERM + NROW * NCOL;
    localparam int RW_LEN  = (MIN_RW_LEN > RUN_LEN) ? MIN_RW_LEN : RUN_LEN;
    localparam int TW      = (NTERM > 1) ? $clog2(NTERM) : 1;
    localparam int RWD     = (NROW > 1) ? $clog2(NROW) : 1;
    localparam int CWD     = (NCOL > 1) ? $clog2(NCOL) : 1;
    localparam int STW     = $clog2(RW_LEN + 1);

    gms_phase_e     phase_w;
    logic [TW-1:0]  term_w;
    logic [RWD-1:0] row_w;
    logic [CWD-1:0] col_w;
    logic [STW-1:0] step_w;
    logic           rw_w, load_w, first_w, last_w;

    logic signed [W-1:0] sc_q   [NTERM];
    logic signed [W-1:0] cf_q   [NTERM][NROW][NCOL];
    logic signed [W-1:0] st_q   [NCOL];
    logic signed [W-1:0] gain_q [NROW][NCOL];
    logic signed [W-1:0] res_q  [NROW];
    logic signed [W-1:0] gacc_q, oacc_q;
    logic signed [W-1:0] m_base, m_a, m_b, m_ofs, m_sum;

    gms_sequencer #(
        .NTERM(NTERM), .NROW(NROW), .NCOL(NCOL), .RW_LEN(RW_LEN),
        .TW(TW), .RWD(RWD), .CWD(CWD), .STW(STW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rewind_i(rewind_i),
        .phase_o(phase_w), .term_o(term_w), .row_o(row_w), .col_o(col_w),
        .step_o(step_w), .rw_o(rw_w), .load_o(load_w), .first_o(first_w),
        .last_o(last_w), .done_o(done_o)
    );

    gms_mac_unit #(.W(W), .FRAC(FRAC)) u_mac (
        .base_i(m_base), .mul_a_i(m_a), .mul_b_i(m_b), .ofs_i(m_ofs), .sum_o(m_sum)
    );

    // Operand selection for the shared multiply-add unit.
    always_comb begin
        m_base = '0;
        m_a    = '0;
        m_b    = '0;
        m_ofs  = '0;
        case (phase_w)
            PH_GAIN: begin
                m_a    = sc_q[term_w];
                m_b    = cf_q[term_w][row_w][col_w];
                m_base = first_w ? '0 : gacc_q;
                m_ofs  = rw_w ? gofs_i : '0;
            end
            PH_OUTP: begin
                m_a    = gain_q[row_w][col_w];
                m_b    = st_q[col_w];
                m_base = first_w ? '0 : oacc_q;
                m_ofs  = rw_w ? oofs_i : '0;
            end
            default: ;
        endcase
    end

    // Operand capture on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTERM; t++) begin
                sc_q[t] <= '0;
                for (int r = 0; r < NROW; r++)
                    for (int c = 0; c < NCOL; c++)
                        cf_q[t][r][c] <= '0;
            end
            for (int c = 0; c < NCOL; c++)
                st_q[c] <= '0;
        end else if (load_w) begin
            for (int t = 0; t < NTERM; t++) begin
                sc_q[t] <= scal_i[t*W +: W];
                for (int r = 0; r < NROW; r++)
                    for (int c = 0; c < NCOL; c++)
                        cf_q[t][r][c] <= coef_i[((t*NROW + r)*NCOL + c)*W +: W];
            end
            for (int c = 0; c < NCOL; c++)
                st_q[c] <= state_i[c*W +: W];
        end
    end

    // Accumulators, gain matrix and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gacc_q <= '0;
            oacc_q <= '0;
            for (int r = 0; r < NROW; r++) begin
                res_q[r] <= '0;
                for (int c = 0; c < NCOL; c++)
                    gain_q[r][c] <= '0;
            end
        end else if (phase_w == PH_GAIN) begin
            gacc_q <= m_sum;
            if (last_w)
                gain_q[row_w][col_w] <= m_sum;
        end else if (phase_w == PH_OUTP) begin
            oacc_q <= m_sum;
            if (last_w)
                res_q[row_w] <= m_sum;
        end
    end

    // Flatten the result words onto the output port.
    generate
        for (genvar r = 0; r < NROW; r++) begin : g_res
            assign res_o[r*W +: W] = res_q[r];
        end
    endgenerate
endmodule

// File: rtl/gain_mac_stage_chk.sv
// Assertion checker for gain_mac_stage, bound to every instance below.
// Tracks the cycles since the last accepted pass with its own counter.
module gain_mac_stage_chk
    import gms_pkg::*;
#(
    parameter int W       = 24,
    parameter int NROW    = 2,
    parameter int RUN_LEN = 108,
    parameter int RW_LEN  = 108,
    parameter int STW     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rewind_i,
    input logic              done_o,
    input logic [NROW*W-1:0] res_o,
    input gms_phase_e        phase_i,
    input logic [STW-1:0]    step_i
);
    localparam int CW = $clog2(RW_LEN + 4) + 1;
    logic [CW-1:0] cnt_q;
    logic          mode_q;

    // Cycle count since acceptance and the kind of pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (phase_i == PH_IDLE && (start_i || rewind_i)) begin
            cnt_q  <= '0;
            mode_q <= !start_i;
        end else if (cnt_q != {CW{1'b1}}) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_q) |-> (cnt_q == CW'(RUN_LEN + 1)));
    a_r9_rewind_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_q) |-> (cnt_q == CW'(RW_LEN + 1)));
    a_r9_pad_only_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_PAD) |-> mode_q);
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_GAIN && step_i == '0) |-> ($past(phase_i) == PH_IDLE));
    a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != PH_OUTP) |=> $stable(res_o));
endmodule

bind gain_mac_stage gain_mac_stage_chk #(
    .W(W), .NROW(NROW), .RUN_LEN(RUN_LEN), .RW_LEN(RW_LEN), .STW(STW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rewind_i(rewind_i),
    .done_o(done_o), .res_o(res_o), .phase_i(phase_w), .step_i(step_w)
);

// File: tb/gain_mac_stage_bench.sv
// Scoreboard bench: the launch task computes expected results and pushes
// them with their expected done cycle; the monitor pops on each done pulse.
module gain_mac_stage_bench;
    localparam int W     = 24;
    localparam int NT    = 8;
    localparam int NR    = 2;
    localparam int NC    = 6;
    localparam int MINRW = 150;
    localparam int RUN_L = 108;
    localparam int RW_L  = 150;
    localparam logic signed [W-1:0] ONE = 24'sh010000;

    typedef struct {
        logic signed [W-1:0] r0;
        logic signed [W-1:0] r1;
        int                  stamp;
        string               tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic rewind_i = 1'b0;
    logic [NT*W-1:0]       scal_i;
    logic [NT*NR*NC*W-1:0] coef_i;
    logic [NC*W-1:0]       state_i;
    logic [W-1:0]          gofs_i;
    logic [W-1:0]          oofs_i;
    logic                  done_o;
    logic [NR*W-1:0]       res_o;

    logic signed [W-1:0] p_sc [NT];
    logic signed [W-1:0] p_cf [NT][NR][NC];
    logic signed [W-1:0] p_st [NC];
    logic signed [W-1:0] s_sc [NT];
    logic signed [W-1:0] s_cf [NT][NR][NC];
    logic signed [W-1:0] s_st [NC];
    logic signed [W-1:0] p_gofs = '0;
    logic signed [W-1:0] p_oofs = '0;
    logic signed [W-1:0] last_r0 = '0;
    logic signed [W-1:0] last_r1 = '0;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    gain_mac_stage #(.MIN_RW_LEN(MINRW)) u_gain_mac_stage (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rewind_i(rewind_i),
        .scal_i(scal_i), .coef_i(coef_i), .state_i(state_i),
        .gofs_i(gofs_i), .oofs_i(oofs_i), .done_o(done_o), .res_o(res_o)
    );

    // Pack bench operand arrays onto the ports.
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            scal_i[t*W +: W] = p_sc[t];
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    coef_i[((t*NR + r)*NC + c)*W +: W] = p_cf[t][r][c];
        end
        for (int c = 0; c < NC; c++)
            state_i[c*W +: W] = p_st[c];
        gofs_i = p_gofs;
        oofs_i = p_oofs;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One rounded multiply-add step with saturation (R2, R4).
    function automatic logic signed [W-1:0] mstep(input logic signed [W-1:0] base,
            input logic signed [W-1:0] a, input logic signed [W-1:0] b,
            input logic signed [W-1:0] ofs);
        longint p, s;
        p = (longint'(a) * longint'(b) + 32768) >>> 16;
        s = longint'(base) + p + longint'(ofs);
        if (s > 64'sd8388607) s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        return W'(s);
    endfunction

    function automatic logic signed [W-1:0] rnd_val();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return W'(int'(seed[31:8] % 24'h20001) - 32'sh10000);
    endfunction

    // Issue a pass; expected values come from the stored operand copy.
    task automatic launch(input bit do_start, input bit do_rw, input string tag);
        exp_t e;
        logic signed [W-1:0] g [NR][NC];
        logic signed [W-1:0] acc, go, oo;
        logic signed [W-1:0] rr [NR];
        bit rwm;
        rwm = !do_start;
        if (do_start) begin
            s_sc = p_sc;
            s_cf = p_cf;
            s_st = p_st;
        end
        go = rwm ? p_gofs : '0;
        oo = rwm ? p_oofs : '0;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                acc = '0;
                for (int t = 0; t < NT; t++)
                    acc = mstep(acc, s_sc[t], s_cf[t][r][c], go);
                g[r][c] = acc;
            end
        for (int r = 0; r < NR; r++) begin
            acc = '0;
            for (int c = 0; c < NC; c++)
                acc = mstep(acc, g[r][c], s_st[c], oo);
            rr[r] = acc;
        end
        @(negedge clk);
        e.r0 = rr[0];
        e.r1 = rr[1];
        e.stamp = cyc + (rwm ? RW_L : RUN_L) + 2;
        e.tag = tag;
        exp_q.push_back(e);
        start_i = do_start;
        rewind_i = do_rw;
        @(negedge clk);
        start_i = 1'b0;
        rewind_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fill_random();
        for (int t = 0; t < NT; t++) begin
            p_sc[t] = rnd_val();
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    p_cf[t][r][c] = rnd_val();
        end
        for (int c = 0; c < NC; c++)
            p_st[c] = rnd_val();
    endtask

    // Monitor: compare results and done timing against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected done", W'(cyc), '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_o[W-1:0] == e.r0, e.tag, "row0", res_o[W-1:0], e.r0);
                check(res_o[2*W-1:W] == e.r1, e.tag, "row1", res_o[2*W-1:W], e.r1);
                check(cyc == e.stamp, {e.tag, " R5/R9"}, "done cycle", W'(cyc), W'(e.stamp));
                last_r0 = e.r0;
                last_r1 = e.r1;
            end
        end
    end

    initial begin
        #(5ns * 150000);
        check(1'b0, "watchdog", "timeout", W'(cyc), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) begin
            p_sc[t] = '0;
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    p_cf[t][r][c] = '0;
        end
        for (int c = 0; c < NC; c++)
            p_st[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(done_o == 1'b0, "R1", "done after reset", W'(done_o), '0);
        check(res_o[W-1:0] == '0, "R1", "row0 after reset", res_o[W-1:0], '0);
        check(res_o[2*W-1:W] == '0, "R1", "row1 after reset", res_o[2*W-1:W], '0);

        // R2/R3 with R8: random operands, nonzero offsets ignored in a start pass.
        fill_random();
        p_gofs = 24'sh001234;
        p_oofs = -24'sh000777;
        launch(1'b1, 1'b0, "R2 R3 R8");
        wait_idle();

        // R2: unit state vector exposes gain column 3 directly.
        fill_random();
        for (int c = 0; c < NC; c++)
            p_st[c] = (c == 3) ? ONE : '0;
        launch(1'b1, 1'b0, "R2 unit");
        wait_idle();

        // R2: rounding half-up, +0.5 LSB rounds to 1, -0.5 LSB rounds to 0.
        for (int t = 0; t < NT; t++) begin
            p_sc[t] = '0;
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    p_cf[t][r][c] = '0;
        end
        p_sc[0] = 24'sh000001;
        p_cf[0][0][0] = 24'sh008000;
        p_cf[0][1][0] = -24'sh008000;
        for (int c = 0; c < NC; c++)
            p_st[c] = (c == 0) ? ONE : '0;
        launch(1'b1, 1'b0, "R2 round");
        wait_idle();

        // R4: positive saturation in row 0, negative in row 1.
        for (int t = 0; t < NT; t++) begin
            p_sc[t] = 24'sh7F0000;
            for (int c = 0; c < NC; c++) begin
                p_cf[t][0][c] = 24'sh7F0000;
                p_cf[t][1][c] = -24'sh7F0000;
            end
        end
        for (int c = 0; c < NC; c++)
            p_st[c] = 24'sh7FFFFF;
        launch(1'b1, 1'b0, "R4");
        wait_idle();

        // R6: start and rewind pulsed mid-pass with new port values.
        fill_random();
        launch(1'b1, 1'b0, "R6");
        repeat (30) @(negedge clk);
        fill_random();
        p_gofs = 24'sh040000;
        start_i = 1'b1;
        rewind_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rewind_i = 1'b0;
        wait_idle();

        // R7/R8/R9: rewind ignores the changed ports and adds offsets.
        fill_random();
        p_gofs = 24'sh000800;
        p_oofs = 24'sh000100;
        launch(1'b0, 1'b1, "R7 R8 R9");
        wait_idle();
        p_gofs = -24'sh003000;
        p_oofs = -24'sh020000;
        launch(1'b0, 1'b1, "R7 R8 R9 neg");
        wait_idle();

        // R10: start and rewind together run a normal pass on new operands.
        fill_random();
        launch(1'b1, 1'b1, "R10");
        wait_idle();

        // R11: results hold while idle.
        repeat (20) @(negedge clk);
        check(res_o[W-1:0] == last_r0, "R11", "row0 hold", res_o[W-1:0], last_r0);
        check(res_o[2*W-1:W] == last_r1, "R11", "row1 hold", res_o[2*W-1:W], last_r1);
        check(exp_q.size() == 0, "R6", "pending results", W'(exp_q.size()), '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule